// File: doc/BRIEF.md
# SPI Clock Mode Adapter

This block lets a serial master that can only produce a mode-3 clock (idle high, shift on the falling edge, sample on the rising edge) drive a peripheral that expects mode 0 (idle low, sample on the rising edge). The SPI mode number is 2 × polarity + phase. Polarity is the idle level of the clock. Phase is 0 when data is captured on the leading edge and 1 when it is captured on the trailing edge. A complementary clock output serves mode-1 and mode-2 peripherals. There is no polarity select: the board wires the peripheral to one output or the other.

An internal hold flag is set by an active-low arm input from a GPIO. While the flag is set, the outgoing clock is forced low. The first low level of the incoming clock clears the flag. The outgoing clock then equals the incoming clock gated by the cleared flag. Because the flag is cleared while the incoming clock is low, the rising edge that ends the first incoming pulse is the first rising edge the peripheral sees. After each byte, software pulses arm low and releases it. This sets the flag again and returns the outgoing clock to its low rest level. All of this is synchronous logic on a system clock, which must run at least four times faster than the serial clock. Both asynchronous inputs pass through a synchronizer. Data lines and chip selects bypass the block.

Top module: `spi_mode_adapter`

## Requirements
- R1: After reset, `sclk_o` is 0 and `sclk_n_o` is 1, and the hold flag is set.
- R2: While the hold flag is set, `sclk_o` stays 0 whatever the level of `m3_sclk_i`. Driving `arm_n_i` low while `m3_sclk_i` is high sets the flag.
- R3: The first low level on `m3_sclk_i` clears the flag without a pulse on `sclk_o`. The next return of `m3_sclk_i` to high is the first rising edge of `sclk_o`.
- R4: Once cleared, the flag stays clear across any number of `m3_sclk_i` pulses while `arm_n_i` stays high, and `sclk_o` follows `m3_sclk_i`.
- R5: A low pulse on `arm_n_i`, then release, while `m3_sclk_i` is high brings `sclk_o` back to 0. It stays 0 until `m3_sclk_i` next goes low and then high.
- R6: When `arm_n_i` is low and `m3_sclk_i` is low in the same cycle, set wins. If `arm_n_i` is then released in the same cycle that `m3_sclk_i` rises, the flag remains set and `sclk_o` stays 0.
- R7: `sclk_n_o` is always the inverse of `sclk_o`.
- R8: With default parameters (two synchronizer stages, registered output), a change of `m3_sclk_i` applied between edges appears on `sclk_o` at the third rising edge of `clk`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| m3_sclk_i | input | 1 | Mode-3 serial clock from the master (idle high) |
| arm_n_i | input | 1 | Active-low arm control from a GPIO; sets the hold flag |
| sclk_o | output | 1 | Gated clock for mode-0 (and mode-3) peripherals |
| sclk_n_o | output | 1 | Inverted gated clock for mode-1 and mode-2 peripherals |

## Verification
Setting the hold flag (arm low) and clearing it (incoming clock low) can both be requested in the same cycle. The bench provokes this by driving both inputs low together, and also inside the random mix, where arm and clock levels are drawn independently. It then releases arm in the very cycle the clock rises. The bench judges priority at the output: if set won, `sclk_o` stays low through that high phase. A design where clear wins would instead pass the clock high.

// File: rtl/spi_mode_adapter_pkg.sv
package spi_mode_adapter_pkg;

   typedef enum logic {
      HOLD_CLEAR = 1'b0,
      HOLD_SET   = 1'b1
   } hold_e;

   // set has priority over clear
   function automatic hold_e hold_next(input hold_e cur, input logic set_req, input logic clr_req);
      if (set_req)      return HOLD_SET;
      else if (clr_req) return HOLD_CLEAR;
      else              return cur;
   endfunction

endpackage

// File: rtl/sma_sync.sv
module sma_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sma_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sma_hold_latch.sv
module sma_hold_latch
   import spi_mode_adapter_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  set_i,
   input  logic  clr_i,
   output hold_e hold_o
);
   hold_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HOLD_SET;
      else        state_q <= hold_next(state_q, set_i, clr_i);
   end

   assign hold_o = state_q;
endmodule

// File: rtl/sma_clk_gate.sv
module sma_clk_gate
   import spi_mode_adapter_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  src_i,
   input  hold_e hold_i,
   output logic  clk_o,
   output logic  clk_n_o
);
   logic pass;
   assign pass = src_i & (hold_i == HOLD_CLEAR);

   generate
      if (OUT_REG) begin : g_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= pass;
         end
         assign clk_o   = out_q;
         assign clk_n_o = ~out_q;
      end else begin : g_comb
         assign clk_o   = pass;
         assign clk_n_o = ~pass;
      end
   endgenerate
endmodule

// File: rtl/spi_mode_adapter.sv
module spi_mode_adapter
   import spi_mode_adapter_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic m3_sclk_i,
   input  logic arm_n_i,
   output logic sclk_o,
   output logic sclk_n_o
);
   localparam int LATENCY = SYNC_STAGES + (OUT_REG ? 1 : 0);

   generate
      if (LATENCY < 2) begin : g_bad_latency
         $error("spi_mode_adapter: latency below synchronizer minimum");
      end
   endgenerate

   logic  sclk_sync;
   logic  arm_sync;
   hold_e held;

   sma_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d_i(m3_sclk_i), .q_o(sclk_sync)
   );

   sma_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_arm (
      .clk(clk), .rst_n(rst_n), .d_i(arm_n_i), .q_o(arm_sync)
   );

   sma_hold_latch u_hold (
      .clk(clk), .rst_n(rst_n),
      .set_i(~arm_sync), .clr_i(~sclk_sync),
      .hold_o(held)
   );

   sma_clk_gate #(.OUT_REG(OUT_REG)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .src_i(sclk_sync), .hold_i(held),
      .clk_o(sclk_o), .clk_n_o(sclk_n_o)
   );
endmodule

// File: rtl/sma_checker.sv
module sma_checker #(
   parameter bit OUT_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic sclk_s,
   input logic arm_s,
   input logic held,
   input logic sclk_o,
   input logic sclk_n_o
);
   // R2 R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_s |=> held);

   // R3
   clear_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_s && !sclk_s) |=> !held);

   // R4
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_s && sclk_s) |=> $stable(held));

   // R7
   compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $fell(sclk_n_o));

   generate
      if (OUT_REG) begin : g_reg_chk
         // R2 R5
         quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            held |=> !sclk_o);
         // R4
         follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !held |=> (sclk_o == $past(sclk_s)));
         // R3
         no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sclk_o) |-> $past(sclk_s));
      end
   endgenerate
endmodule

bind spi_mode_adapter sma_checker #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk_s(sclk_sync), .arm_s(arm_sync),
   .held(held), .sclk_o(sclk_o), .sclk_n_o(sclk_n_o)
);

// File: tb/spi_mode_adapter_test.sv
module spi_mode_adapter_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m3_sclk = 1'b1;
   logic arm_n = 1'b1;
   logic sclk_o, sclk_n_o;

   int checks = 0;
   int failures = 0;
   bit hold_m = 1'b1;

   always #2.5 clk = ~clk;

   spi_mode_adapter uut (
      .clk(clk), .rst_n(rst_n), .m3_sclk_i(m3_sclk), .arm_n_i(arm_n),
      .sclk_o(sclk_o), .sclk_n_o(sclk_n_o)
   );

   function automatic bit model_hold(bit h, bit s, bit a);
      if (!a)      return 1'b1;
      else if (!s) return 1'b0;
      else         return h;
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // apply levels, let them settle, compare to model
   task automatic step(bit s, bit a, string req);
      @(negedge clk);
      m3_sclk = s;
      arm_n   = a;
      hold_m  = model_hold(hold_m, s, a);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(req, sclk_o, s & ~hold_m);
      check("R7", sclk_n_o, ~sclk_o);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      check("R1", sclk_o, 1'b0);
      check("R1", sclk_n_o, 1'b1);
      rst_n = 1'b1;
      step(1, 1, "R1");
      // R2: armed, input idle high -> low
      step(1, 0, "R2");
      step(1, 1, "R2");
      // R3: first low must not pulse the output
      @(negedge clk);
      m3_sclk = 1'b0;
      hold_m  = 1'b0;
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sclk_o) seen = 1'b1;
         end
         check("R3", seen, 1'b0);
      end
      step(1, 1, "R3");
      // R4: many pulses follow
      for (int i = 0; i < 6; i++) begin
         step(0, 1, "R4");
         step(1, 1, "R4");
      end
      // R8: latency of a falling input edge
      @(negedge clk);
      m3_sclk = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check("R8", sclk_o, 1'b1);
      @(posedge clk); #1;
      check("R8", sclk_o, 1'b0);
      step(0, 1, "R8");
      step(1, 1, "R8");
      // R5: re-arm pulse after a byte
      step(1, 0, "R5");
      step(1, 1, "R5");
      step(1, 1, "R5");
      step(0, 1, "R5");
      step(1, 1, "R5");
      // R6: both active, then release arm as clock rises
      step(0, 0, "R6");
      step(1, 1, "R6");
      step(0, 1, "R6");
      step(1, 1, "R6");
      // random mix
      for (int i = 0; i < 400; i++) begin
         bit s = 1'($urandom_range(0, 1));
         bit a = ($urandom_range(0, 3) != 0);
         step(s, a, "R4");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule